// File: doc/BRIEF.md
# CIC Decimation Filter

This block lowers the sample rate of a signed data stream by an integer factor without a single multiplier. Samples arrive one per clock at most, each marked by a valid strobe. A chain of accumulators runs at the input rate. A down-sampler keeps one accumulator result out of every `RATE` accepted inputs. That result then passes through a chain of difference stages that run at the reduced rate. Each difference stage subtracts the value it received `DIFF_DELAY` low-rate samples earlier.

All internal registers and the output are sized for the full worst-case growth, so the result is exact and carries no rounding. Accumulators may overflow, because only the final difference is meaningful. Cycles with the input strobe low change nothing. An integrator front end is normally placed after a sigma-delta modulator or a mixer, and this block's reduced-rate output feeds a compensation filter further down the chain.

Top module: `cic_decimator`

## Requirements
- R1: While `rst` is high, and after its release until the first kept sample has passed through, `outValid` is low. A synchronous reset clears every accumulator, difference-stage history and the rate counter to zero.
- R2: Each of the `NUM_STAGES` accumulators adds its input to its own running value once per accepted sample. Stage 0 takes the sign-extended input. Stage k takes the registered value of stage k-1 before that cycle's update, so each stage adds one accepted-sample delay.
- R3: A rate counter that starts at zero counts accepted inputs modulo `RATE`. The accumulator result produced by every `RATE`-th accepted input (counts RATE, 2*RATE, ...) is kept, and no other.
- R4: A cycle with `inValid` low leaves the accumulators, the counter and the difference stages unchanged, so gaps in the input do not alter any output value.
- R5: Each of the `NUM_STAGES` difference stages, on every kept sample, outputs its input minus the input it received `DIFF_DELAY` kept samples earlier (zero before that). Stage j takes the registered output of stage j-1 before that update.
- R6: The output is `IN_W + NUM_STAGES*ceil(log2(RATE*DIFF_DELAY))` bits wide, signed two's complement. A constant input x settles to exactly x*(RATE*DIFF_DELAY)^NUM_STAGES, including the most negative and most positive input codes.
- R7: Accumulators wrap modulo 2^width and never saturate, so long runs of large inputs still give exact outputs.
- R8: `outValid` is high for one cycle, during the second clock after the edge that accepts each kept input. `outData` holds the new result during that cycle.
- R9: A reset asserted in the middle of a stream discards all history, and the outputs that follow match a filter started from zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| inValid | input | 1 | Input sample strobe |
| inData | input | IN_W | Signed input sample |
| outValid | output | 1 | Output sample strobe, once per RATE accepted inputs |
| outData | output | IN_W+NUM_STAGES*ceil(log2(RATE*DIFF_DELAY)) | Signed full-precision filtered result |

## Verification
The bench drives long runs of full-scale positive and negative constants. A design that saturated its accumulators, or grew them too little, would settle on a wrong DC level instead of x*(RATE*DIFF_DELAY)^NUM_STAGES. Random gaps in the input strobe show up a counter or accumulator that advances on idle cycles, because later outputs would then drift from the model. An impulse response exposes a wrong difference delay or a missing pipeline stage, and strobe timing is compared against the edge that accepted each kept sample. A reset in the middle of a stream catches history that survives reset, because the next impulse response would be corrupted.

// File: rtl/cic_pkg.sv
package cic_pkg;

  // strobes issued by the rate control to the datapath
  typedef struct packed {
    logic intEn;   // accept one input into the accumulator chain
    logic combEn;  // advance the low-rate difference chain
    logic clear;   // synchronous clear of all state
  } cicStrobes_t;

endpackage

// File: rtl/cic_ctrl.sv
module cic_ctrl
  import cic_pkg::*;
#(
  parameter int RATE = 4
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        inValid,
  output cicStrobes_t strobes,
  output logic        outValid
);

  localparam int CNT_W = (RATE > 2) ? $clog2(RATE) : 1;
  localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(RATE - 1);

  logic [CNT_W-1:0] phaseCnt;
  logic             keepPend;
  logic             outValidReg;
  logic             pastRst;

  always_ff @(posedge clk) begin
    if (rst) begin
      phaseCnt    <= '0;
      keepPend    <= 1'b0;
      outValidReg <= 1'b0;
    end else begin
      if (inValid) begin
        phaseCnt <= (phaseCnt == LAST_CNT) ? '0 : phaseCnt + 1'b1;
      end
      keepPend    <= inValid && (phaseCnt == LAST_CNT);
      outValidReg <= keepPend;
    end
  end

  always_ff @(posedge clk) begin
    pastRst <= rst;
  end

  always_comb begin
    strobes.intEn  = inValid;
    strobes.combEn = keepPend;
    strobes.clear  = rst;
  end

  assign outValid = outValidReg;

  // R1: one edge after reset, the counter and output strobe are cleared
  always_ff @(posedge clk) begin
    if (pastRst) begin
      a_r1_reset_clear: assert (phaseCnt == '0 && !outValidReg && !keepPend);
    end
  end

  a_r3_cnt_bound: assert property (@(posedge clk) disable iff (rst)
    phaseCnt <= LAST_CNT);

  a_r4_cnt_hold: assert property (@(posedge clk) disable iff (rst)
    !inValid |=> $stable(phaseCnt));

  a_r8_single_pulse: assert property (@(posedge clk) disable iff (rst)
    outValidReg |=> !outValidReg);

endmodule

// File: rtl/cic_datapath.sv
module cic_datapath
  import cic_pkg::*;
#(
  parameter int IN_W       = 16,
  parameter int NUM_STAGES = 3,
  parameter int DIFF_DELAY = 2,
  parameter int GROWTH     = 9,
  parameter int ACC_W      = IN_W + GROWTH
) (
  input  logic                    clk,
  input  cicStrobes_t             strobes,
  input  logic [IN_W-1:0]         inData,
  output logic signed [ACC_W-1:0] combOut
);

  logic signed [ACC_W-1:0] integVal [NUM_STAGES];
  logic signed [ACC_W-1:0] combVal  [NUM_STAGES];
  logic signed [ACC_W-1:0] extIn;

  assign extIn = {{GROWTH{inData[IN_W-1]}}, inData};

  // accumulator chain at the input rate
  for (genvar k = 0; k < NUM_STAGES; k++) begin : g_integ
    logic signed [ACC_W-1:0] accReg;
    logic signed [ACC_W-1:0] accIn;
    if (k == 0) begin : g_first
      assign accIn = extIn;
    end else begin : g_chain
      assign accIn = integVal[k-1];
    end
    always_ff @(posedge clk) begin
      if (strobes.clear) begin
        accReg <= '0;
      end else if (strobes.intEn) begin
        accReg <= accReg + accIn;  // wraps, R7
      end
    end
    assign integVal[k] = accReg;
  end

  // difference chain at the decimated rate
  for (genvar j = 0; j < NUM_STAGES; j++) begin : g_comb
    logic signed [ACC_W-1:0] diffReg;
    logic signed [ACC_W-1:0] diffIn;
    logic signed [ACC_W-1:0] histReg [DIFF_DELAY];
    if (j == 0) begin : g_first
      assign diffIn = integVal[NUM_STAGES-1];
    end else begin : g_chain
      assign diffIn = combVal[j-1];
    end
    always_ff @(posedge clk) begin
      if (strobes.clear) begin
        diffReg <= '0;
        for (int i = 0; i < DIFF_DELAY; i++) histReg[i] <= '0;
      end else if (strobes.combEn) begin
        diffReg    <= diffIn - histReg[DIFF_DELAY-1];
        histReg[0] <= diffIn;
        for (int i = 1; i < DIFF_DELAY; i++) histReg[i] <= histReg[i-1];
      end
    end
    assign combVal[j] = diffReg;
  end

  assign combOut = combVal[NUM_STAGES-1];

  a_r4_integ_hold: assert property (@(posedge clk) disable iff (strobes.clear)
    !strobes.intEn |=> $stable(integVal[0]));

  a_r5_comb_hold: assert property (@(posedge clk) disable iff (strobes.clear)
    !strobes.combEn |=> $stable(combVal[NUM_STAGES-1]));

endmodule

// File: rtl/cic_decimator.sv
module cic_decimator
  import cic_pkg::*;
#(
  parameter int IN_W       = 16,
  parameter int NUM_STAGES = 3,
  parameter int RATE       = 4,
  parameter int DIFF_DELAY = 2,
  localparam int GROWTH    = NUM_STAGES * $clog2(RATE * DIFF_DELAY),
  localparam int OUT_W     = IN_W + GROWTH
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             inValid,
  input  logic [IN_W-1:0]  inData,
  output logic             outValid,
  output logic [OUT_W-1:0] outData
);

  cicStrobes_t         strobes;
  logic signed [OUT_W-1:0] combOut;

  initial begin
    a_param_in_w: assert (IN_W >= 1 && IN_W <= 32);
    a_param_rate: assert (RATE >= 2 && NUM_STAGES >= 1 && DIFF_DELAY >= 1);
  end

  cic_ctrl #(.RATE(RATE)) ctrl_i (
    .clk      (clk),
    .rst      (rst),
    .inValid  (inValid),
    .strobes  (strobes),
    .outValid (outValid)
  );

  cic_datapath #(
    .IN_W       (IN_W),
    .NUM_STAGES (NUM_STAGES),
    .DIFF_DELAY (DIFF_DELAY),
    .GROWTH     (GROWTH),
    .ACC_W      (OUT_W)
  ) dp_i (
    .clk     (clk),
    .strobes (strobes),
    .inData  (inData),
    .combOut (combOut)
  );

  assign outData = combOut;

endmodule

// File: tb/cic_decimator_tb_top.sv
module cic_decimator_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int IN_W  = 16;
  localparam int N     = 3;
  localparam int R     = 4;
  localparam int M     = 2;
  localparam int ACC_W = IN_W + N * $clog2(R * M);
  localparam longint GAIN = longint'(R * M) ** N;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic inValid = 1'b0;
  logic [IN_W-1:0] inData = '0;
  logic outValid;
  logic [ACC_W-1:0] outData;

  int cyc = 0;
  int checks = 0;
  int errors = 0;

  logic [ACC_W-1:0] expVal[$];
  int               expCyc[$];
  string            expTag[$];
  logic [ACC_W-1:0] lastSeen = '0;

  longint sAcc[N];
  longint cOut[N];
  longint hist[N][$];
  int     mCnt;

  always #(CLK_PERIOD/2) clk = ~clk;

  cic_decimator #(.IN_W(IN_W), .NUM_STAGES(N), .RATE(R), .DIFF_DELAY(M)) dut_i (
    .clk(clk), .rst(rst), .inValid(inValid), .inData(inData),
    .outValid(outValid), .outData(outData)
  );

  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", tag, act, exp, cyc);
    end
  endtask

  function automatic void modelReset();
    mCnt = 0;
    for (int k = 0; k < N; k++) begin
      sAcc[k] = 0;
      cOut[k] = 0;
      hist[k].delete();
      for (int i = 0; i < M; i++) hist[k].push_back(0);
    end
    expVal.delete(); expCyc.delete(); expTag.delete();
  endfunction

  // monitor: sampled on the falling edge
  always @(negedge clk) begin
    if (rst) begin
      check(!outValid, "R1 outValid during reset", longint'(outValid), 0);
    end else if (outValid) begin
      lastSeen = outData;
      if (expVal.size() == 0) begin
        check(1'b0, "R3 unexpected outValid", 1, 0);
      end else begin
        check(cyc == expCyc[0], "R8 output timing", cyc, expCyc[0]);
        check(outData == expVal[0], expTag[0],
              longint'($signed(outData)), longint'($signed(expVal[0])));
        void'(expVal.pop_front()); void'(expCyc.pop_front()); void'(expTag.pop_front());
      end
    end else if (expCyc.size() != 0 && expCyc[0] <= cyc) begin
      check(1'b0, "R3 missing outValid", 0, 1);
      void'(expVal.pop_front()); void'(expCyc.pop_front()); void'(expTag.pop_front());
    end
  end

  // drive one accepted sample on the next rising edge and advance the model
  task automatic pushSample(input longint x, input string tag);
    longint d, inp;
    inValid = 1'b1;
    inData  = IN_W'(x);
    for (int k = N - 1; k >= 1; k--) sAcc[k] += sAcc[k-1];
    sAcc[0] += x;
    mCnt++;
    if (mCnt == R) begin
      mCnt = 0;
      d = sAcc[N-1];
      for (int j = N - 1; j >= 0; j--) begin
        inp = (j == 0) ? d : cOut[j-1];
        cOut[j] = inp - hist[j].pop_back();
        hist[j].push_front(inp);
      end
      expVal.push_back(ACC_W'(cOut[N-1]));
      expCyc.push_back(cyc + 2);
      expTag.push_back(tag);
    end
    @(negedge clk);
    inValid = 1'b0;
  endtask

  task automatic idle(input int n);
    inValid = 1'b0;
    repeat (n) @(negedge clk);
  endtask

  task automatic doReset();
    rst = 1'b1;
    modelReset();
    repeat (3) @(negedge clk);
    rst = 1'b0;
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    check(1'b0, "watchdog expired", cyc, 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    modelReset();
    @(negedge clk);
    doReset();
    check(!outValid && outData == '0, "R1 state after reset", longint'(outData), 0);

    // R2 R5: impulse response
    pushSample(1000, "R2 R5 impulse");
    for (int i = 0; i < 47; i++) pushSample(0, "R2 R5 impulse");
    idle(4);

    // R4 R3: random data with random gaps
    for (int i = 0; i < 400; i++) begin
      pushSample(longint'($signed(16'($urandom))), "R4 gapped random");
      idle($urandom_range(0, 2));
    end
    idle(4);

    // R6: full-scale positive constant
    for (int i = 0; i < 80; i++) pushSample(32767, "R6 max positive");
    idle(4);
    check(lastSeen == ACC_W'(longint'(32767) * GAIN), "R6 positive DC gain",
          longint'($signed(lastSeen)), longint'(32767) * GAIN);

    // R6: full-scale negative constant
    for (int i = 0; i < 160; i++) pushSample(-32768, "R6 max negative");
    idle(4);
    check(lastSeen == ACC_W'(longint'(-32768) * GAIN), "R6 negative DC gain",
          longint'($signed(lastSeen)), longint'(-32768) * GAIN);

    // R7: long run that wraps the accumulators
    for (int i = 0; i < 3000; i++) pushSample(30000, "R7 wrap run");
    idle(4);
    check(lastSeen == ACC_W'(longint'(30000) * GAIN), "R7 DC after wrap",
          longint'($signed(lastSeen)), longint'(30000) * GAIN);

    // R9: reset in mid-stream, then a fresh impulse
    for (int i = 0; i < 7; i++) pushSample(longint'($signed(16'($urandom))), "R9 pre-reset");
    idle(4);
    doReset();
    check(!outValid, "R1 R9 outValid after reset", longint'(outValid), 0);
    pushSample(-777, "R9 post-reset impulse");
    for (int i = 0; i < 39; i++) pushSample(0, "R9 post-reset impulse");
    idle(6);

    check(expVal.size() == 0, "R3 all outputs delivered", expVal.size(), 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule